// File: doc/BRIEF.md
# Output Address Size Fault Checker

This block judges one address per cycle against the address size limits of a one- or two-stage address translation. The caller gives it a 3-bit code for the physical address size the machine implements and a 3-bit output size code programmed for each stage. It also gives the stage enables, the input width of the second stage in bits, and the programmed starting level of the second stage. With each request comes a tagged address and the walk level that produced it. The tag marks the address as one of four kinds: a translation table base, a table or descriptor address, an output address, or a flat input address that arrives while stage 1 is off.

One cycle later the block returns its verdict. The verdict is no fault, an address size fault or a stage-2 translation fault, with the stage and the level to report. The block is purely a judge. Walk sequencing and memory traffic belong to the caller.

Top module: `addr_size_check`

## Requirements
- R1: Size codes decode as 0=32, 1=36, 2=40, 3=42, 4=44 and 5=48 bits. Codes 6 and 7 mean 48 bits.
- R2: A stage's effective output size is the smaller of its programmed size and the implemented size.
- R3: A base-address request (kind 0) with any bit set at or above the effective size of its stage gives an address size fault at level 0, whatever level was supplied.
- R4: A descriptor request (kind 1) or an output request (kind 2) with a bit set at or above the effective size of its stage gives an address size fault. The fault carries that stage (fault_stage 0 = first, 1 = second) and the supplied level.
- R5: A flat input request (kind 3) is always a first-stage request. While stage 1 is disabled, any bit at or above the implemented size gives a first-stage level 0 address size fault. While stage 1 is enabled, a flat input request never faults.
- R6: While stage 2 is disabled, a first-stage output request never gives a translation fault.
- R7: While stage 2 is enabled, a first-stage output request, or a flat input request with stage 1 disabled, that passes its size check but has a bit set at or above s2_in_width gives a second-stage level 0 translation fault.
- R8: When both the first-stage size check and the second-stage width check fail, the address size fault is reported.
- R9: While stage 2 is enabled, every second-stage request (stage 1, kinds 0 to 2) whose s2_start_lvl is above the parameter S2_LVL_MAX gives a second-stage level 0 translation fault. This outcome takes precedence over all others.
- R10: The response appears exactly one cycle after req_valid. Without a request, all outputs are 0 on the next cycle. At most one fault kind is raised at a time, and every output is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| impl_code | input | 3 | Implemented physical size code |
| s1_size_code | input | 3 | Programmed first-stage output size code |
| s2_size_code | input | 3 | Programmed second-stage output size code |
| s1_on | input | 1 | First stage enabled |
| s2_on | input | 1 | Second stage enabled |
| s2_in_width | input | 7 | Second-stage input width in bits |
| s2_start_lvl | input | 2 | Programmed second-stage starting level |
| req_addr | input | AW | Address to judge |
| req_kind | input | 2 | 0 base, 1 descriptor, 2 output, 3 flat input |
| req_stage | input | 1 | 0 first stage, 1 second stage |
| req_level | input | 2 | Walk level that produced the address |
| rsp_valid | output | 1 | Verdict valid |
| flt_size | output | 1 | Address size fault |
| flt_xlat | output | 1 | Translation fault |
| flt_stage | output | 1 | Stage of the fault |
| flt_level | output | 2 | Level of the fault |

## Verification
The sweep places addresses on both sides of every size boundary: one address just below each decoded width and one exactly at it. Because of this, a wrong decode or a missing clamp shows up as a fault that is off by one boundary. Base requests are issued at nonzero levels, so a design that passes the level through for a base fault reports the wrong level. Output requests are swept with stage 2 both on and off. A design that swaps the priority between the size check and the width check would report a translation fault where an address size fault belongs. The starting-level cases confirm that an illegal start level overrides even an address that fits.

// File: rtl/addr_size_check.sv
module addr_size_check #(
  parameter int AW = 56,
  parameter int S2_LVL_MAX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    impl_code,
  input  logic [2:0]    s1_size_code,
  input  logic [2:0]    s2_size_code,
  input  logic          s1_on,
  input  logic          s2_on,
  input  logic [6:0]    s2_in_width,
  input  logic [1:0]    s2_start_lvl,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  input  logic          req_stage,
  input  logic [1:0]    req_level,
  output logic          rsp_valid,
  output logic          flt_size,
  output logic          flt_xlat,
  output logic          flt_stage,
  output logic [1:0]    flt_level
);
  localparam logic [1:0] K_BASE = 2'd0, K_OUT = 2'd2, K_FLAT = 2'd3;

  function automatic int bits_of(input logic [2:0] c);
    case (c)
      3'd0: return 32;
      3'd1: return 36;
      3'd2: return 40;
      3'd3: return 42;
      3'd4: return 44;
      default: return 48;
    endcase
  endfunction

  function automatic logic above(input logic [AW-1:0] a, input int w);
    return (w >= AW) ? 1'b0 : ((a >> w) != '0);
  endfunction

  int impl_w, eff1, eff2, lim_w;
  assign impl_w = bits_of(impl_code);
  assign eff1   = (bits_of(s1_size_code) < impl_w) ? bits_of(s1_size_code) : impl_w;
  assign eff2   = (bits_of(s2_size_code) < impl_w) ? bits_of(s2_size_code) : impl_w;

  logic first, flat, size_hit, lvl_bad, wid_hit;
  assign flat  = (req_kind == K_FLAT);
  assign first = flat || !req_stage;
  assign lim_w = flat ? impl_w : (first ? eff1 : eff2);

  assign size_hit = !(flat && s1_on) && above(req_addr, lim_w);
  assign lvl_bad  = !first && s2_on && (int'(s2_start_lvl) > S2_LVL_MAX);
  assign wid_hit  = first && s2_on && (req_kind == K_OUT || (flat && !s1_on))
                    && above(req_addr, int'(s2_in_width));

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid <= 1'b0;
      flt_size  <= 1'b0;
      flt_xlat  <= 1'b0;
      flt_stage <= 1'b0;
      flt_level <= 2'd0;
    end else begin
      rsp_valid <= 1'b1;
      flt_size  <= 1'b0;
      flt_xlat  <= 1'b0;
      flt_stage <= 1'b0;
      flt_level <= 2'd0;
      if (lvl_bad) begin
        flt_xlat  <= 1'b1;
        flt_stage <= 1'b1;
      end else if (size_hit) begin
        flt_size  <= 1'b1;
        flt_stage <= !first;
        flt_level <= (req_kind == K_BASE || flat) ? 2'd0 : req_level;
      end else if (wid_hit) begin
        flt_xlat  <= 1'b1;
        flt_stage <= 1'b1;
      end
    end
  end
endmodule

module addr_size_check_sva #(
  parameter int AW = 56,
  parameter int S2_LVL_MAX = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          s1_on,
  input logic          s2_on,
  input logic [1:0]    s2_start_lvl,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_kind,
  input logic          req_stage,
  input logic          rsp_valid,
  input logic          flt_size,
  input logic          flt_xlat,
  input logic          flt_stage,
  input logic [1:0]    flt_level
);
  p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flt_size, flt_xlat}));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !flt_size && !flt_xlat);

  p_base_lvl0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |=> (!flt_size || flt_level == 2'd0));

  p_flat_on_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3 && s1_on) |=> (!flt_size && !flt_xlat));

  p_no_xlat_s2off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !s2_on) |=> !flt_xlat);

  p_zero_addr_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == '0) |=> !flt_size);

  p_start_lvl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && s2_on && req_stage && req_kind != 2'd3
     && int'(s2_start_lvl) > S2_LVL_MAX)
    |=> (flt_xlat && flt_stage && flt_level == 2'd0));
endmodule

bind addr_size_check addr_size_check_sva #(.AW(AW), .S2_LVL_MAX(S2_LVL_MAX)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .s1_on(s1_on), .s2_on(s2_on),
  .s2_start_lvl(s2_start_lvl), .req_addr(req_addr), .req_kind(req_kind),
  .req_stage(req_stage), .rsp_valid(rsp_valid), .flt_size(flt_size),
  .flt_xlat(flt_xlat), .flt_stage(flt_stage), .flt_level(flt_level)
);

// File: tb/test_addr_size_check.sv
module test_addr_size_check;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 56;
  localparam int LMAX = 2;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [2:0] impl_code = 0, s1_size_code = 0, s2_size_code = 0;
  logic s1_on = 0, s2_on = 0;
  logic [6:0] s2_in_width = 7'd48;
  logic [1:0] s2_start_lvl = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_kind = 0;
  logic req_stage = 0;
  logic [1:0] req_level = 0;
  logic rsp_valid, flt_size, flt_xlat, flt_stage;
  logic [1:0] flt_level;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_size_check #(.AW(AW), .S2_LVL_MAX(LMAX)) i_addr_size_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .impl_code(impl_code),
    .s1_size_code(s1_size_code), .s2_size_code(s2_size_code), .s1_on(s1_on),
    .s2_on(s2_on), .s2_in_width(s2_in_width), .s2_start_lvl(s2_start_lvl),
    .req_addr(req_addr), .req_kind(req_kind), .req_stage(req_stage),
    .req_level(req_level), .rsp_valid(rsp_valid), .flt_size(flt_size),
    .flt_xlat(flt_xlat), .flt_stage(flt_stage), .flt_level(flt_level)
  );

  function automatic int width_of(input logic [2:0] c);
    int t[6] = '{32, 36, 40, 42, 44, 48};
    return (c > 3'd5) ? 48 : t[c];
  endfunction

  function automatic logic big(input logic [AW-1:0] a, input int w);
    logic [AW:0] one = 1;
    if (w >= AW) return 1'b0;
    return {1'b0, a} >= (one << w);
  endfunction

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {rsp_valid, flt_size, flt_xlat, flt_stage, flt_level};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (v,size,xlat,stage,level)", tag, act, exp);
    end
  endtask

  // Drive one request, then sample its registered verdict one cycle later.
  task automatic issue(input string tag, input logic [5:0] exp);
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(tag, exp);
  endtask

  // Expected verdict from the requirement text; returns the deciding tag.
  task automatic model(output string tag, output logic [5:0] exp);
    int iw, e1, e2, lim;
    logic fl, fs;
    iw = width_of(impl_code);
    e1 = mn(width_of(s1_size_code), iw);
    e2 = mn(width_of(s2_size_code), iw);
    fl = (req_kind == 2'd3);
    fs = fl || !req_stage;
    lim = fl ? iw : (fs ? e1 : e2);
    if (!fs && s2_on && int'(s2_start_lvl) > LMAX) begin
      tag = "R9"; exp = 6'b101100;
    end else if (fl && s1_on) begin
      tag = "R5"; exp = 6'b100000;
    end else if (big(req_addr, lim)) begin
      tag = fl ? "R5" : (req_kind == 2'd0 ? "R3" : "R4");
      exp = {3'b110, !fs, (req_kind == 2'd0 || fl) ? 2'd0 : req_level};
    end else if (fs && s2_on && (req_kind == 2'd2 || fl) && big(req_addr, int'(s2_in_width))) begin
      tag = "R7"; exp = 6'b101100;
    end else begin
      tag = (fs && !s2_on && req_kind == 2'd2) ? "R6" : "R10";
      exp = 6'b100000;
    end
  endtask

  initial begin
    string tg;
    logic [5:0] ex;
    repeat (3) @(negedge clk);
    check("R10 reset", 6'b0);
    rst_n = 1;
    @(negedge clk);
    check("R10 idle", 6'b0);

    // R1: reserved implemented code acts as 48 bits
    impl_code = 3'd7; s1_size_code = 3'd6; req_kind = 2'd1; req_stage = 0; req_level = 2'd2;
    req_addr = (56'd1 << 47); issue("R1 reserved fits", 6'b100000);
    req_addr = (56'd1 << 48); issue("R1 reserved over", 6'b110010);
    // R2: programmed 48 clamped to implemented 32
    impl_code = 3'd0; s1_size_code = 3'd5; req_addr = (56'd1 << 32);
    issue("R2 clamp", 6'b110010);
    // R8: size fault wins over width fault
    impl_code = 3'd4; s1_size_code = 3'd5; s2_on = 1; s2_in_width = 7'd40;
    req_kind = 2'd2; req_level = 2'd3; req_addr = (56'd1 << 45);
    issue("R8 priority", 6'b110011);
    req_addr = (56'd1 << 41);
    issue("R7 width only", 6'b101100);

    // Sweep
    for (int ic = 0; ic < 8; ic++)
      for (int oc = 0; oc < 8; oc++)
        for (int kd = 0; kd < 4; kd++)
          for (int st = 0; st < 2; st++)
            for (int s2 = 0; s2 < 2; s2++)
              for (int s1 = 0; s1 < 2; s1++)
                for (int k = 0; k < 14; k++) begin
                  impl_code = 3'(ic); s1_size_code = 3'(oc); s2_size_code = 3'(oc ^ 3);
                  req_kind = 2'(kd); req_stage = st[0]; s2_on = s2[0]; s1_on = s1[0];
                  s2_in_width = 7'(32 + 4 * (oc % 4));
                  s2_start_lvl = 2'd0; req_level = 2'(k % 4);
                  if (k < 12) req_addr = (56'd1 << width_of(3'(k / 2))) - ((k % 2 == 0) ? 56'd1 : 56'd0);
                  else if (k == 12) req_addr = '0;
                  else req_addr = (56'd1 << 55);
                  model(tg, ex);
                  issue(tg, ex);
                end

    // R9: starting level sweep
    impl_code = 3'd5; s1_size_code = 3'd5; s2_size_code = 3'd5; s1_on = 1; s2_in_width = 7'd48;
    for (int lv = 0; lv < 4; lv++)
      for (int kd = 0; kd < 3; kd++)
        for (int s2 = 0; s2 < 2; s2++) begin
          s2_start_lvl = 2'(lv); req_kind = 2'(kd); req_stage = 1; s2_on = s2[0];
          req_level = 2'd1; req_addr = 56'h10;
          model(tg, ex);
          issue((lv > LMAX && s2 == 1) ? "R9" : tg, ex);
        end
    req_stage = 0; req_kind = 2'd2; s2_on = 1; s2_start_lvl = 2'd3;
    issue("R9 first-stage unaffected", 6'b100000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule